// File: doc/BRIEF.md
# JK-Entry Synchronous Shift Register

A register of `WIDTH` stages (four by default) that can load a parallel word or shift its contents toward the higher-index stage on the rising clock edge. The mode input picks between the two. During a shift, the first stage (bit 0) is not fed by a plain serial bit. It is fed by a J / K-bar entry function, so the same two pins can make it toggle, hold, or take D-type serial data while the other stages shift.

Every stage drives a true output. The block also drives the inverted value of the last stage (bit `WIDTH-1`). An active-low master reset clears the register at once, independent of the clock. It wins over any load or shift that is pending on the same edge.

Typical uses are serial-to-parallel and parallel-to-serial conversion. Because the first stage can toggle, the register can also act as a simple pattern or counter front end.

Top module: `jkshift_reg`

## Requirements
- R1: The stored value changes only on a rising clock edge (reset excepted). Input changes between edges leave the outputs unchanged.
- R2: With `shift_sel` = 0, a rising edge copies `par_in[i]` into stage i for every i.
- R3: With `shift_sel` = 1, a rising edge moves stage i-1 into stage i for every i from 1 to `WIDTH-1`.
- R4: During a shift with `j_in` = 1 and `k_n_in` = 0, stage 0 takes the complement of its previous value.
- R5: During a shift with `j_in` = 0 and `k_n_in` = 1, stage 0 keeps its previous value.
- R6: During a shift with `j_in` equal to `k_n_in`, stage 0 takes that common level (D-type entry).
- R7: `rst_n` = 0 clears every stage immediately, without waiting for a clock edge. The register stays cleared across clock edges while reset is held, even when a load is selected.
- R8: `q_last_n` always equals the complement of `q_out[WIDTH-1]`. It is 1 while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state is updated on the rising edge |
| rst_n | input | 1 | Asynchronous master reset, active low |
| shift_sel | input | 1 | 1 = shift toward higher index, 0 = parallel load |
| j_in | input | 1 | J entry input for stage 0 |
| k_n_in | input | 1 | Active-low K entry input for stage 0 |
| par_in | input | WIDTH | Parallel load word, bit i goes to stage i |
| q_out | output | WIDTH | True output of every stage, bit 0 is the first stage |
| q_last_n | output | 1 | Inverted output of stage WIDTH-1 |

## Verification
Two functions meet in the same cycle in this block: a load or shift that is selected at a clock edge, and a master reset that is held low across that edge.

The bench provokes the collision in two steps. It pulls `rst_n` low in the middle of a cycle while a non-zero load word is presented, and it judges that the outputs clear right away, before any edge arrives. It then keeps reset low across rising edges with the load still selected, and it expects all-zero true outputs and a high inverted output.

Reset is released away from the edge. The next edge must then perform the selected operation exactly as the reference model predicts.

// File: rtl/jkshift_pkg.sv
// Package: shared width default and the stage-0 entry function.
// Assumes: callers pass single-bit values.
package jkshift_pkg;

    localparam int unsigned DEF_WIDTH = 4;

    // Next value of the first stage during a shift: J sets from 0, K-bar keeps a 1.
    function automatic logic jk_next(input logic cur, input logic j, input logic k_n);
        return (j & ~cur) | (k_n & cur);
    endfunction

endpackage

// File: rtl/jkshift_head.sv
// Module: jkshift_head
// Computes the serial value entering stage 0 from the J / K-bar pins and the
// present stage-0 value. Purely combinational; assumes a registered cur_q.
module jkshift_head (
    input  logic cur_q,
    input  logic j_in,
    input  logic k_n_in,
    output logic entry_d
);
    import jkshift_pkg::*;

    // Evaluate the entry function for this cycle.
    always_comb begin
        entry_d = jk_next(cur_q, j_in, k_n_in);
    end
endmodule

// File: rtl/jkshift_cell.sv
// Module: jkshift_cell
// One register stage: picks the serial input when shifting, the parallel bit
// when loading. Cleared asynchronously by an active-low reset.
module jkshift_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_sel,
    input  logic ser_d,
    input  logic par_d,
    output logic q
);
    logic next_d;

    // Select between shift and load data.
    always_comb begin
        next_d = shift_sel ? ser_d : par_d;
    end

    // Store the selected bit; reset overrides the clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= next_d;
        end
    end
endmodule

// File: rtl/jkshift_chk.sv
// Module: jkshift_chk
// Checker for jkshift_reg, attached by bind. Assumes WIDTH >= 2.
module jkshift_chk #(
    parameter int unsigned WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shift_sel,
    input logic             j_in,
    input logic             k_n_in,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] q_out,
    input logic             q_last_n
);
    AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_sel |=> q_out == $past(par_in)); // R2

    AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        shift_sel |=> q_out[WIDTH-1:1] == $past(q_out[WIDTH-2:0])); // R3

    AST_HEAD_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_sel && j_in && !k_n_in) |=> q_out[0] != $past(q_out[0])); // R4

    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_sel && !j_in && k_n_in) |=> $stable(q_out[0])); // R5

    AST_HEAD_DTYPE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_sel && (j_in == k_n_in)) |=> q_out[0] == $past(j_in)); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (q_out == '0 && q_last_n)); // R7

    AST_LAST_INV: assert property (@(negedge clk)
        q_last_n == ~q_out[WIDTH-1]); // R8
endmodule

bind jkshift_reg jkshift_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .shift_sel(shift_sel), .j_in(j_in),
    .k_n_in(k_n_in), .par_in(par_in), .q_out(q_out), .q_last_n(q_last_n)
);

// File: rtl/jkshift_reg.sv
// Module: jkshift_reg
// Parallel-load / shift-up register with J / K-bar entry into stage 0 and an
// inverted copy of the last stage. Assumes WIDTH >= 2.
module jkshift_reg #(
    parameter int unsigned WIDTH = jkshift_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_sel,
    input  logic             j_in,
    input  logic             k_n_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q_out,
    output logic             q_last_n
);
    localparam int unsigned LAST = WIDTH - 1;

    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] ser_d;
    logic             head_d;

    jkshift_head u_head (
        .cur_q   (stage_q[0]),
        .j_in    (j_in),
        .k_n_in  (k_n_in),
        .entry_d (head_d)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            // Stage 0 is fed by the entry function.
            assign ser_d[i] = head_d;
        end else begin : g_rest
            // Other stages are fed by their lower neighbour.
            assign ser_d[i] = stage_q[i-1];
        end

        jkshift_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .shift_sel (shift_sel),
            .ser_d     (ser_d[i]),
            .par_d     (par_in[i]),
            .q         (stage_q[i])
        );
    end

    // Drive the true outputs and the inverted last stage.
    always_comb begin
        q_out    = stage_q;
        q_last_n = ~stage_q[LAST];
    end
endmodule

// File: tb/jkshift_reg_bench.sv
// Bench: random and directed stimulus against a bench reference model.
module jkshift_reg_bench;
    localparam int unsigned W      = 4;
    localparam time         CLK_PER = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_sel = 1'b0;
    logic         j_in = 1'b0;
    logic         k_n_in = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] q_out;
    logic         q_last_n;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] model = '0;
    bit done = 1'b0;

    jkshift_reg #(.WIDTH(W)) u_jkshift_reg (
        .clk(clk), .rst_n(rst_n), .shift_sel(shift_sel), .j_in(j_in),
        .k_n_in(k_n_in), .par_in(par_in), .q_out(q_out), .q_last_n(q_last_n)
    );

    always #(CLK_PER/2) clk = ~clk;

    // Expected state after one edge, written from the requirements.
    function automatic logic [W-1:0] ref_next(input logic [W-1:0] cur, input logic sel,
                                              input logic j, input logic kn,
                                              input logic [W-1:0] par);
        logic [W-1:0] nx;
        if (!sel) return par;
        nx = cur << 1;
        if (j && !kn)      nx[0] = ~cur[0];
        else if (!j && kn) nx[0] = cur[0];
        else               nx[0] = j;
        return nx;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Apply one edge and compare at mid-high phase.
    task automatic step(input logic sel, input logic j, input logic kn, input logic [W-1:0] par);
        string tag;
        shift_sel = sel; j_in = j; k_n_in = kn; par_in = par;
        @(posedge clk);
        model = ref_next(model, sel, j, kn, par);
        #(CLK_PER/4);
        if (!sel)          tag = "R2";
        else if (j && !kn) tag = "R4";
        else if (!j && kn) tag = "R5";
        else               tag = "R6";
        check(tag, q_out, model);
        if (sel) check("R3", {1'b0, q_out[W-1:1]}, {1'b0, model[W-1:1]});
        check("R8", {{(W-1){1'b0}}, q_last_n}, {{(W-1){1'b0}}, ~model[W-1]});
    endtask

    initial begin
        void'($urandom(32'd4242));
        #(CLK_PER*3/4);
        check("R7", q_out, '0);
        check("R8", {{(W-1){1'b0}}, q_last_n}, {{(W-1){1'b0}}, 1'b1});
        @(negedge clk); rst_n = 1'b1;

        // Directed: load, then toggle / hold / D-type entry.
        step(1'b0, 1'b0, 1'b0, 4'b1010);
        step(1'b1, 1'b1, 1'b0, 4'b0000);
        step(1'b1, 1'b1, 1'b0, 4'b1111);
        step(1'b1, 1'b0, 1'b1, 4'b0000);
        step(1'b1, 1'b1, 1'b1, 4'b0000);
        step(1'b1, 1'b0, 1'b0, 4'b1111);
        step(1'b0, 1'b0, 1'b0, 4'b1111);

        // R1: inputs wiggle between edges, outputs must not move.
        shift_sel = 1'b0; par_in = 4'b0001; j_in = 1'b1; k_n_in = 1'b0;
        #1;
        check("R1", q_out, model);

        // R7: reset mid-cycle with a load pending clears at once and holds.
        rst_n = 1'b0;
        #1;
        model = '0;
        check("R7", q_out, '0);
        @(posedge clk); #1;
        check("R7", q_out, '0);
        check("R8", {{(W-1){1'b0}}, q_last_n}, {{(W-1){1'b0}}, 1'b1});
        @(negedge clk); rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, 4'b0110);

        // Random mix.
        for (int n = 0; n < 400; n++) begin
            logic [W-1:0] p;
            logic s, jj, kk;
            p  = W'($urandom);
            s  = ($urandom % 4) != 0;
            jj = 1'($urandom);
            kk = 1'($urandom);
            step(s, jj, kk, p);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PER*20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule